// File: doc/BRIEF.md
# Paged MDIO Register Access Bridge

This block lets a local master read and write 32-bit registers that lie behind a 16-bit management bus. The local master makes a request with a byte address, write data, a direction flag and a valid strobe. The bridge turns that request into three management commands. The first command selects the page of the register. The other two carry the two 16-bit halves, and the bridge picks their order from the direction of the access. When the last command completes, the bridge pulses a done flag. For reads, it also presents the reassembled 32-bit word.

On the downstream side the bridge drives a command interface in clause-22 form: PHY address, register number, 16-bit write data and direction. A separate MDIO master engine, which produces the serial bit waveform, consumes these commands. The bridge holds each command steady until the engine acknowledges it. For reads, the engine returns the 16-bit data in the same cycle as the acknowledge.

Top module: `mdio_page_bridge`

## Requirements
- R1: The two lowest byte-address bits are ignored. The word index equals the byte address with bits 1:0 cleared, shifted right by one. The first command of every access is a write to PHY address 0x18, register 0, with data equal to word-index bits 16:8 zero-extended to 16 bits.
- R2: Both half commands use PHY address 0x10 ORed with word-index bits 7:5. The lower half uses register number word-index bits 4:0. The upper half sits at word index plus one, so its register number has bit 0 set.
- R3: A read issues the lower-half read first and then the upper-half read. Both half commands have the write flag low.
- R4: A write first sends the upper half, carrying data bits 31:16. It then sends the lower half, carrying bits 15:0. All three commands have the write flag high.
- R5: When a read completes, the read-data output equals {upper-half data, lower-half data}. This value is valid in the cycle that done is high.
- R6: The request ready output is low from the accepting edge until done. No new command appears until the engine acknowledges the current one. While a command waits for its acknowledge, its PHY address, register number, data and direction stay constant.
- R7: Done is high for exactly one cycle. Done rises one cycle after the acknowledge of the third command, so with an engine latency of L cycles it comes 3(L+1)+1 cycles after acceptance. Ready is high again in the cycle after done.
- R8: Address, data and direction are captured at acceptance. Changing them afterwards has no effect on the access in progress.
- R9: A synchronous active-high reset returns the block to idle: ready high, command valid low, done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Local request strobe |
| reqReady | output | 1 | Bridge idle; a request is accepted while this and reqValid are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Byte address of the 32-bit register |
| reqWdata | input | 32 | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Assembled read data |
| cmdValid | output | 1 | Management command pending |
| cmdAck | input | 1 | Engine completes the pending command |
| cmdWrite | output | 1 | Command direction, 1 = write |
| cmdPhy | output | 5 | Command PHY address |
| cmdReg | output | 5 | Command register number |
| cmdWdata | output | 16 | Command write data |
| cmdRdata | input | 16 | Read data, valid with cmdAck |

## Verification
Each command is due on the first falling edge after the accepting edge, or after the acknowledge of the previous command. The engine model acknowledges a command after a chosen number of waiting cycles, 0 to 2, and logs the command at the moment it acknowledges it. The bench counts falling edges from acceptance and requires done at exactly edge 3(L+1)+1. It then samples read data at that same edge and checks at the following edge that done has fallen and ready has risen. All outputs are sampled on falling edges, half a period away from the registers that drive them.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_HALF_A,
    ST_HALF_B,
    ST_FINISH
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request fields
    logic selPage;    // present the page-select command
    logic selHigh;    // half command targets the upper half
    logic storeLow;   // latch returned data as lower half
    logic storeHigh;  // latch returned data as upper half
  } dp_ctrl_t;

endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  input  logic     cmdAck,
  input  logic     wrFlag,
  output dp_ctrl_t ctrl,
  output logic     reqReady,
  output logic     cmdValid,
  output logic     rspDone
);

  seq_state_t state, stateNext;
  logic inHalf;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_PAGE;
      ST_PAGE:   if (cmdAck)   stateNext = ST_HALF_A;
      ST_HALF_A: if (cmdAck)   stateNext = ST_HALF_B;
      ST_HALF_B: if (cmdAck)   stateNext = ST_FINISH;
      ST_FINISH:               stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  assign inHalf   = (state == ST_HALF_A) || (state == ST_HALF_B);
  assign reqReady = (state == ST_IDLE);
  assign cmdValid = (state == ST_PAGE) || inHalf;
  assign rspDone  = (state == ST_FINISH);

  always_comb begin
    ctrl.capture   = reqReady && reqValid;
    ctrl.selPage   = (state == ST_PAGE);
    // reads: lower then upper; writes: upper then lower
    ctrl.selHigh   = (state == ST_HALF_B) ^ wrFlag;
    ctrl.storeLow  = inHalf && cmdAck && !wrFlag && !ctrl.selHigh;
    ctrl.storeHigh = inHalf && cmdAck && !wrFlag && ctrl.selHigh;
  end

endmodule

// File: rtl/mdio_bridge_dp.sv
module mdio_bridge_dp
  import mdio_bridge_pkg::*;
#(
  parameter int          ADDR_W     = 18,
  parameter int          DATA_W     = 32,
  parameter int          PHY_W      = 5,
  parameter int          REG_W      = 5,
  parameter int          SEL_W      = 3,
  parameter logic [4:0]  PAGE_PHY   = 5'h18,
  parameter logic [4:0]  PAGE_REG   = 5'h00,
  parameter logic [4:0]  PORT_BASE  = 5'h10
) (
  input  logic                clk,
  input  logic                rst,
  input  dp_ctrl_t            ctrl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                reqWrite,
  input  logic [DATA_W/2-1:0] cmdRdata,
  output logic                wrFlag,
  output logic                cmdWrite,
  output logic [PHY_W-1:0]    cmdPhy,
  output logic [REG_W-1:0]    cmdReg,
  output logic [DATA_W/2-1:0] cmdWdata,
  output logic [DATA_W-1:0]   rspRdata
);

  localparam int HALF_W   = DATA_W / 2;
  localparam int WIDX_W   = ADDR_W - 1;
  localparam int PAGE_LSB = REG_W + SEL_W;
  localparam int PAGE_W   = WIDX_W - PAGE_LSB;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [HALF_W-1:0] rdLow, rdHigh;
  logic [WIDX_W-1:0] wordIdx, halfIdx;
  logic [PAGE_W-1:0] pageVal;
  logic [HALF_W-1:0] halfData;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      dataReg <= '0;
      wrFlag  <= 1'b0;
    end else if (ctrl.capture) begin
      addrReg <= reqAddr;
      dataReg <= reqWdata;
      wrFlag  <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdLow  <= '0;
      rdHigh <= '0;
    end else begin
      if (ctrl.storeLow)  rdLow  <= cmdRdata;
      if (ctrl.storeHigh) rdHigh <= cmdRdata;
    end
  end

  // 16-bit word index of a 32-bit aligned register (always even)
  assign wordIdx  = {addrReg[ADDR_W-1:2], 1'b0};
  // upper half lives at index + 1: no carry since index is even
  assign halfIdx  = {wordIdx[WIDX_W-1:1], ctrl.selHigh};
  assign pageVal  = wordIdx[WIDX_W-1:PAGE_LSB];
  assign halfData = ctrl.selHigh ? dataReg[DATA_W-1:HALF_W] : dataReg[HALF_W-1:0];

  always_comb begin
    if (ctrl.selPage) begin
      cmdPhy   = PAGE_PHY;
      cmdReg   = PAGE_REG;
      cmdWdata = {{(HALF_W-PAGE_W){1'b0}}, pageVal};
      cmdWrite = 1'b1;
    end else begin
      cmdPhy   = PORT_BASE | {{(PHY_W-SEL_W){1'b0}}, halfIdx[PAGE_LSB-1:REG_W]};
      cmdReg   = halfIdx[REG_W-1:0];
      cmdWdata = halfData;
      cmdWrite = wrFlag;
    end
  end

  assign rspRdata = {rdHigh, rdLow};

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspDone,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                cmdValid,
  input  logic                cmdAck,
  output logic                cmdWrite,
  output logic [4:0]          cmdPhy,
  output logic [4:0]          cmdReg,
  output logic [DATA_W/2-1:0] cmdWdata,
  input  logic [DATA_W/2-1:0] cmdRdata
);

  dp_ctrl_t ctrl;
  logic     wrFlag;

  mdio_bridge_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .cmdAck   (cmdAck),
    .wrFlag   (wrFlag),
    .ctrl     (ctrl),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .rspDone  (rspDone)
  );

  mdio_bridge_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqWrite (reqWrite),
    .cmdRdata (cmdRdata),
    .wrFlag   (wrFlag),
    .cmdWrite (cmdWrite),
    .cmdPhy   (cmdPhy),
    .cmdReg   (cmdReg),
    .cmdWdata (cmdWdata),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspDone,
  input logic              cmdValid,
  input logic              cmdAck,
  input logic              cmdWrite,
  input logic [4:0]        cmdPhy,
  input logic [4:0]        cmdReg,
  input logic [DATA_W/2-1:0] cmdWdata
);

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (reqReady && !cmdValid && !rspDone));

  assert_page_first_R1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> (cmdValid && cmdWrite && cmdPhy == 5'h18 && cmdReg == 5'h00));

  assert_cmd_held_R6: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdAck) |=> (cmdValid && $stable(cmdPhy) && $stable(cmdReg)
                               && $stable(cmdWdata) && $stable(cmdWrite)));

  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (cmdValid || rspDone) |-> !reqReady);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rspDone |=> (!rspDone && reqReady));

  assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rspDone) |-> $past(cmdValid && cmdAck));

  assert_half_phy_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdPhy != 5'h18) |-> (cmdPhy[4:3] == 2'b10));

endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspDone  (rspDone),
  .cmdValid (cmdValid),
  .cmdAck   (cmdAck),
  .cmdWrite (cmdWrite),
  .cmdPhy   (cmdPhy),
  .cmdReg   (cmdReg),
  .cmdWdata (cmdWdata)
);

// File: tb/tb_mdio_page_bridge.sv
module tb_mdio_page_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspDone;
  logic [31:0] rspRdata;
  logic        cmdValid;
  logic        cmdAck = 1'b0;
  logic        cmdWrite;
  logic [4:0]  cmdPhy;
  logic [4:0]  cmdReg;
  logic [15:0] cmdWdata;
  logic [15:0] cmdRdata = '0;

  int checkCnt = 0;
  int failCnt  = 0;

  // engine model state
  int          latency = 0;
  int          waitCnt = 0;
  int          logN = 0;
  logic [4:0]  logPhy [0:7];
  logic [4:0]  logReg [0:7];
  logic [15:0] logData[0:7];
  logic        logWr  [0:7];
  logic [8:0]  curPage = '0;

  mdio_page_bridge dut (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata),
    .cmdValid(cmdValid), .cmdAck(cmdAck), .cmdWrite(cmdWrite),
    .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdWdata(cmdWdata), .cmdRdata(cmdRdata)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] regContent(logic [8:0] pg, logic [4:0] phy, logic [4:0] rg);
    return {pg[5:0], phy, rg};
  endfunction

  // engine: acknowledges after `latency` waiting cycles, logs each command
  always @(negedge clk) begin
    if (cmdAck) begin
      cmdAck  = 1'b0;
      waitCnt = 0;
    end
    if (cmdValid && !rst) begin
      if (waitCnt == latency) begin
        cmdAck = 1'b1;
        if (logN < 8) begin
          logPhy[logN]  = cmdPhy;
          logReg[logN]  = cmdReg;
          logData[logN] = cmdWdata;
          logWr[logN]   = cmdWrite;
        end
        logN++;
        if (cmdWrite && cmdPhy == 5'h18 && cmdReg == 5'h00) curPage = cmdWdata[8:0];
        cmdRdata = regContent(curPage, cmdPhy, cmdReg);
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkCmd(input int idx, input string req, input logic [4:0] ePhy,
                          input logic [4:0] eReg, input logic [15:0] eDat, input logic eWr,
                          input bit chkData);
    check(logPhy[idx] == ePhy, req, $sformatf("cmd%0d phy", idx), 32'(logPhy[idx]), 32'(ePhy));
    check(logReg[idx] == eReg, req, $sformatf("cmd%0d reg", idx), 32'(logReg[idx]), 32'(eReg));
    check(logWr[idx] == eWr,   req, $sformatf("cmd%0d dir", idx), 32'(logWr[idx]), 32'(eWr));
    if (chkData)
      check(logData[idx] == eDat, req, $sformatf("cmd%0d data", idx), 32'(logData[idx]), 32'(eDat));
  endtask

  task automatic doAccess(input bit wr, input logic [17:0] addr, input logic [31:0] wd,
                          input int lat);
    logic [16:0] widx;
    logic [8:0]  pg;
    logic [4:0]  phy, rLo, rHi;
    int          n;
    widx = {addr[17:2], 1'b0};
    pg   = widx[16:8];
    phy  = 5'h10 | {2'b00, widx[7:5]};
    rLo  = widx[4:0];
    rHi  = widx[4:0] | 5'd1;

    @(negedge clk);
    latency  = lat;
    logN     = 0;
    check(reqReady == 1'b1, "R6", "ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqWdata = wd;
    @(negedge clk);
    // R8: scramble inputs once accepted
    reqValid = 1'b0;
    reqWrite = ~wr;
    reqAddr  = ~addr;
    reqWdata = ~wd;
    check(reqReady == 1'b0, "R6", "ready low after accept", 32'(reqReady), 32'd0);
    n = 1;
    while (!rspDone && n < 64) begin
      @(negedge clk);
      n++;
    end
    check(n == 3 * (lat + 1) + 1, "R7", "done cycle", 32'(n), 32'(3 * (lat + 1) + 1));
    check(logN == 3, "R6", "command count", 32'(logN), 32'd3);
    // R1 page select, R8 captured address
    checkCmd(0, "R1", 5'h18, 5'h00, {7'b0, pg}, 1'b1, 1'b1);
    if (wr) begin
      // R4 upper first, R2 addressing
      checkCmd(1, "R4", phy, rHi, wd[31:16], 1'b1, 1'b1);
      checkCmd(2, "R4", phy, rLo, wd[15:0],  1'b1, 1'b1);
    end else begin
      // R3 lower first, R2 addressing
      checkCmd(1, "R3", phy, rLo, 16'h0, 1'b0, 1'b0);
      checkCmd(2, "R3", phy, rHi, 16'h0, 1'b0, 1'b0);
      check(rspRdata == {regContent(pg, phy, rHi), regContent(pg, phy, rLo)}, "R5",
            "read data", rspRdata, {regContent(pg, phy, rHi), regContent(pg, phy, rLo)});
    end
    check(phy[4:3] == 2'b10 && logPhy[1] == logPhy[2], "R2", "half phy",
          32'(logPhy[2]), 32'(phy));
    @(negedge clk);
    check(rspDone == 1'b0, "R7", "done single cycle", 32'(rspDone), 32'd0);
    check(reqReady == 1'b1, "R7", "ready after done", 32'(reqReady), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "reset ready", 32'(reqReady), 32'd1);
    check(cmdValid == 1'b0, "R9", "reset cmdValid", 32'(cmdValid), 32'd0);
    check(rspDone == 1'b0,  "R9", "reset done", 32'(rspDone), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < 24; i++) begin
      for (int lat = 0; lat < 3; lat++) begin
        logic [17:0] a;
        logic [31:0] d;
        a = 18'((i * 32'h2A5C7 + lat * 32'h1113) & 32'h3FFFF);
        d = 32'h9E3779B9 * (i + 1) + 32'(lat);
        doAccess(1'b1, a, d, lat);
        doAccess(1'b0, a, d, lat);
      end
    end
    // boundaries: lowest and highest addresses, low bits set
    doAccess(1'b0, 18'h00003, 32'h0, 0);
    doAccess(1'b1, 18'h3FFFF, 32'hFFFF0000, 1);
    doAccess(1'b0, 18'h3FFFC, 32'h0, 2);

    // R9: reset in mid-sequence returns to idle
    @(negedge clk);
    latency  = 2;
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqAddr  = 18'h01234;
    @(negedge clk);
    reqValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(reqReady == 1'b1 && cmdValid == 1'b0 && rspDone == 1'b0, "R9",
          "mid-access reset", {29'b0, reqReady, cmdValid, rspDone}, 32'h4);
    doAccess(1'b0, 18'h00404, 32'h0, 0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule